// File: doc/BRIEF.md
# Unaligned Range Region Encoder

This block converts a memory protection range, given as a base address, a byte count, a starting region slot, attribute bits and an enable flag, into at most two region descriptors for a memory protection unit that only accepts power-of-two regions split into eight equal subregions. Each descriptor carries a slot index, a base address and a 16-bit size word. The size word packs a subregion-disable mask in bits 15:8, the region size exponent minus one in bits 5:1, and the enable flag in bit 0. Bits 7:6 are zero.

A range whose size is a power of two takes one descriptor. Any other size is accepted only when all of its set bits fall within six consecutive bit positions, counting down from its most significant set bit. Such a range is covered by a first region that is twice the size of that top bit, with its unused upper eighths disabled. When the low three bits of the window are not all zero, a second region follows. It is one quarter the size of the top bit, starts at the first unoccupied eighth of the first region, and is trimmed in the same way. Requests the encoding cannot express raise an error flag instead of producing descriptors.

A one-cycle `start` pulse captures the request. The results appear on the next cycle together with a one-cycle `done` pulse, and they stay unchanged until the next `start`.

Top module: `range_region_encoder`

## Requirements
- R1: A size of zero completes with `err`=0, `d0_valid`=0 and `d1_valid`=0.
- R2: Let k be the position of the most significant set bit of the size. If k < 5, the request sets `err`=1 and produces no descriptors.
- R3: A power-of-two size with k ≥ 5 produces only descriptor 0. It uses the requested slot and base, and its size word is {8'h00, 2'b00, 5'(k-1), enable}.
- R4: A size that is not a power of two sets `err` if k < 7, or if any set bit lies below bit k-5.
- R5: For an accepted size that is not a power of two, let b = size >> (k-2). Descriptor 0 uses the requested slot and base, and its size word is {~((1<<b)-1) as 8 bits, 2'b00, 5'(k), enable}.
- R6: Let s2 = (1 << ((size >> (k-5)) & 7)) - 1. When s2 is nonzero, descriptor 1 is valid with slot = requested slot + 1, base = base + b·2^(k-2), and size word {~s2 as 8 bits, 2'b00, 5'(k-3), enable}. When s2 is zero, descriptor 1 is not valid.
- R7: A nonzero s2 sets `err` when k < 10, or when the requested slot is 6 (the exempt slot, which may not take a second region) or 7 (which has no following slot).
- R8: `done` is high exactly in the cycle after `start`. `err` and `d0_valid` are never high together, and `d1_valid` implies `d0_valid`.
- R9: All result outputs hold their values in every cycle that follows a cycle without `start`.
- R10: Bit 0 of every valid size word equals the captured enable, and `d_attr` returns the captured attribute bits for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the request on this cycle |
| base_i | input | 32 | Range base address |
| size_i | input | 32 | Range size in bytes |
| region_i | input | 3 | First region slot |
| enable_i | input | 1 | Enable flag placed in the size words |
| attr_i | input | 16 | Attribute bits carried with the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request cannot be encoded |
| d_attr | output | 16 | Captured attribute bits |
| d0_valid | output | 1 | Descriptor 0 present |
| d0_region | output | 3 | Descriptor 0 slot |
| d0_base | output | 32 | Descriptor 0 base address |
| d0_size | output | 16 | Descriptor 0 size word |
| d1_valid | output | 1 | Descriptor 1 present |
| d1_region | output | 3 | Descriptor 1 slot |
| d1_base | output | 32 | Descriptor 1 base address |
| d1_size | output | 16 | Descriptor 1 size word |

## Verification
The assertions check on every cycle the handshake timing and the holding of results, the exclusion between the error flag and the valid flags, and the fixed relations between a second descriptor and the first: the next slot, an exponent three lower, the same enable bit, and a higher base. Whether each individual range is accepted, and the exact mask, exponent and base values it produces, can only be shown by the bench. The bench sweeps every six-bit window pattern at each top-bit position, adds sizes with stray low bits, and runs the two worked examples at 24 KiB and 104 KiB.

// File: rtl/range_region_encoder.sv
module range_region_encoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_i,
  input  logic [31:0] size_i,
  input  logic [2:0]  region_i,
  input  logic        enable_i,
  input  logic [15:0] attr_i,
  output logic        done,
  output logic        err,
  output logic [15:0] d_attr,
  output logic        d0_valid,
  output logic [2:0]  d0_region,
  output logic [31:0] d0_base,
  output logic [15:0] d0_size,
  output logic        d1_valid,
  output logic [2:0]  d1_region,
  output logic [31:0] d1_base,
  output logic [15:0] d1_size
);

  logic [4:0]  msb;
  logic        pow2, stray, need2, bad;
  logic [2:0]  blk, sel2;
  logic [7:0]  mask1, mask2;
  logic [31:0] win, base1;
  logic [15:0] word0, word1;

  always_comb begin
    msb = 5'd0;
    for (int i = 0; i < 32; i++)
      if (size_i[i]) msb = 5'(i);
  end

  assign pow2  = (size_i & (size_i - 32'd1)) == 32'd0;
  assign win   = 32'h3f << (msb - 5'd5);
  assign stray = (size_i & ~win) != 32'd0;
  assign blk   = 3'(size_i >> (msb - 5'd2));
  assign sel2  = 3'(size_i >> (msb - 5'd5));
  assign mask1 = ~((8'd1 << blk) - 8'd1);
  assign mask2 = ~((8'd1 << sel2) - 8'd1);
  assign need2 = !pow2 && sel2 != 3'd0;
  assign base1 = base_i + (32'(blk) << (msb - 5'd2));

  always_comb begin
    bad = 1'b0;
    if (msb < 5'd5) bad = 1'b1;
    else if (!pow2) begin
      if (msb < 5'd7 || stray) bad = 1'b1;
      else if (need2 && (msb < 5'd10 || region_i >= 3'd6)) bad = 1'b1;
    end
  end

  assign word0 = pow2 ? {8'h00, 2'b00, msb - 5'd1, enable_i}
                      : {mask1, 2'b00, msb, enable_i};
  assign word1 = {mask2, 2'b00, msb - 5'd3, enable_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; err <= 1'b0; d_attr <= '0;
      d0_valid <= 1'b0; d0_region <= '0; d0_base <= '0; d0_size <= '0;
      d1_valid <= 1'b0; d1_region <= '0; d1_base <= '0; d1_size <= '0;
    end else begin
      done <= start;
      if (start) begin
        d_attr    <= attr_i;
        err       <= (size_i != 32'd0) && bad;
        d0_valid  <= (size_i != 32'd0) && !bad;
        d1_valid  <= (size_i != 32'd0) && !bad && need2;
        d0_region <= region_i;
        d0_base   <= base_i;
        d0_size   <= word0;
        d1_region <= region_i + 3'd1;
        d1_base   <= base1;
        d1_size   <= word1;
      end
    end
  end

  p_done_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_only_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_err_excl_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && d0_valid));
  p_second_needs_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d0_valid);
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(err) && $stable(d0_valid) && $stable(d1_valid) &&
               $stable(d0_size) && $stable(d1_size) && $stable(d0_base) &&
               $stable(d1_base) && $stable(d_attr));
  p_second_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d1_region == d0_region + 3'd1);
  p_second_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d1_size[5:1] == d0_size[5:1] - 5'd3);
  p_second_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d1_base > d0_base);
  p_second_limits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d0_region < 3'd6 && d0_size[5:1] >= 5'd10);
  p_enable_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> d1_size[0] == d0_size[0]);

endmodule

// File: tb/range_region_encoder_tb.sv
module range_region_encoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_i = '0, size_i = '0;
  logic [2:0]  region_i = '0;
  logic        enable_i = 1'b0;
  logic [15:0] attr_i = '0;
  logic done, err, d0_valid, d1_valid;
  logic [15:0] d_attr, d0_size, d1_size;
  logic [2:0]  d0_region, d1_region;
  logic [31:0] d0_base, d1_base;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  range_region_encoder u_dut (.*);

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] b, input logic [31:0] s, input logic [2:0] r,
                     input logic en, input logic [15:0] at, input bit hold);
    int k;
    int blk, s2;
    bit e_err, v0, v1;
    logic [15:0] w0, w1;
    logic [31:0] b1;
    string tag;
    k = 0;
    for (int i = 0; i < 32; i++) if (s[i]) k = i;
    e_err = 0; v0 = 0; v1 = 0; w0 = 0; w1 = 0; b1 = 0; tag = "R1";
    if (s != 0) begin
      if (k < 5) begin e_err = 1; tag = "R2"; end
      else if ((s & (s - 1)) == 0) begin
        v0 = 1; w0 = 16'(((k - 1) << 1) | en); tag = "R3";
      end else if (k < 7 || (s & ~(32'h3f << (k - 5))) != 0) begin
        e_err = 1; tag = "R4";
      end else begin
        blk = int'(s >> (k - 2));
        s2  = (1 << ((s >> (k - 5)) & 7)) - 1;
        if (s2 != 0 && (k < 10 || r >= 6)) begin e_err = 1; tag = "R7"; end
        else begin
          v0 = 1; tag = "R5";
          w0 = 16'(((~((1 << blk) - 1) & 255) << 8) | (k << 1) | en);
          if (s2 != 0) begin
            v1 = 1; tag = "R6";
            w1 = 16'(((~s2 & 255) << 8) | ((k - 3) << 1) | en);
            b1 = b + (32'(blk) << (k - 2));
          end
        end
      end
    end
    @(negedge clk);
    base_i = b; size_i = s; region_i = r; enable_i = en; attr_i = at; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R8", "done", 64'(done), 64'd1);
    for (int p = 0; p < (hold ? 2 : 1); p++) begin
      if (p == 1) begin
        repeat (3) @(negedge clk);
        tag = "R9";
        check(done === 1'b0, tag, "done low", 64'(done), 64'd0);
      end
      check(err === e_err && d0_valid === v0 && d1_valid === v1, tag, "err/v0/v1",
            64'({err, d0_valid, d1_valid}), 64'({e_err, v0, v1}));
      check(d_attr === at, "R10", "attr", 64'(d_attr), 64'(at));
      if (v0)
        check(d0_size === w0 && d0_base === b && d0_region === r, tag, "desc0",
              {d0_size, d0_base, 13'd0, d0_region}, {w0, b, 13'd0, r});
      if (v1)
        check(d1_size === w1 && d1_base === b1 && d1_region === 3'(r + 1), tag, "desc1",
              {d1_size, d1_base, 13'd0, d1_region}, {w1, b1, 13'd0, 3'(r + 1)});
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(done === 1'b0 && err === 1'b0 && d0_valid === 1'b0 && d1_valid === 1'b0,
          "R8", "reset state", 64'({done, err, d0_valid, d1_valid}), 64'd0);
    rst_n = 1'b1;
    run(32'h200c_2000, 32'h0000_6000, 3'd0, 1'b1, 16'h1234, 1'b1);
    check(d0_size === 16'hc01d && d1_valid === 1'b0, "R5", "24K word",
          64'(d0_size), 64'hc01d);
    run(32'h100a_8000, 32'h0001_a000, 3'd4, 1'b1, 16'h0f0f, 1'b1);
    check(d0_size === 16'hc021 && d1_size === 16'hf01b && d1_base === 32'h100c_0000,
          "R6", "104K words", {d0_size, d1_size, d1_base}, {16'hc021, 16'hf01b, 32'h100c_0000});
    run(32'h100a_8000, 32'h0001_a000, 3'd6, 1'b1, 16'h0, 1'b0);
    run(32'h100a_8000, 32'h0001_a000, 3'd7, 1'b1, 16'h0, 1'b0);
    run(32'h0, 32'h0, 3'd2, 1'b1, 16'hbeef, 1'b1);
    for (int k = 0; k < 25; k++)
      for (int pat = 0; pat < 64; pat++) begin
        run(32'h1000_0000 + 32'(pat) * 32'h1000, ((32'(64 | pat)) << k) >> 6,
            3'(pat), pat[3], 16'(pat * 37 + k), (pat % 16) == 5);
        if (k >= 6 && pat[0])
          run(32'h2000_0000, (((32'(64 | pat)) << k) >> 6) | 32'd1, 3'(k), pat[1],
              16'(k), 1'b0);
      end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule